// File: doc/BRIEF.md
# Banked Scratchpad Arbiter with Traffic Classes

This block is the front end of a shared on-chip scratchpad that several requesters use at once. The requesters are vector cores and streaming accelerators. Each one issues 64-bit word reads and writes. The storage is split into single-port RAM banks. Four banks form a slice, and the scratchpad is built from a parameterised number of slices. Every bank has its own arbiter, so requests that land in different banks are served in the same cycle.

Each request carries a one-bit traffic class.
- Class 1 marks latency-intolerant processor traffic. It wins a bank over class 0 traffic.
- Class 0 marks latency-tolerant accelerator traffic.
- A class 0 request that keeps losing is promoted after a fixed number of denied cycles, so accelerators are never starved.

Read data comes back on the requester's own response port one cycle after the grant. A requester that is not granted keeps its request on the inputs until it is granted.

Top module: `spad_xbar`

## Requirements
- R1: Addresses are word addresses. The low log2(banks) bits select the bank, and the remaining upper bits select the row within that bank. The number of banks is four times NUM_SLICES. Each bank holds BANK_DEPTH words of 64 bits (4096 in the full-size configuration).
- R2: Each bank grants at most one requester per cycle. A grant is only ever given to a requester whose req_valid is high in that cycle.
- R3: Every bank that has at least one valid request grants exactly one requester in that same cycle. Requests to distinct banks are therefore all granted together.
- R4: A granted write stores its data at the addressed word. A later granted read of that word, from any requester, returns the stored data.
- R5: At a given bank, a class 1 request is granted ahead of a class 0 request unless that class 0 request has been promoted.
- R6: Requesters of the same class that contend for one bank are served round-robin. Two such requesters that keep requesting alternate grants.
- R7: A class 0 request that has been denied for STARVE_LIMIT (8) consecutive cycles is promoted above class 1 for one grant. Promoted requests are served before all others. The denial count restarts after the grant. No class 0 request waits more than STARVE_LIMIT plus NUM_REQ cycles.
- R8: A granted read raises rsp_valid on the granting requester's port exactly one cycle after the grant, with the read data on rsp_rdata. A write produces no response. rsp_rdata is all zeros whenever rsp_valid is low.
- R9: During and after reset, no response is pending. With no valid request, no grant is given.
- R10: A requester whose valid request is not granted keeps req_valid high, and keeps its address, write flag, class and write data unchanged, until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_REQ | Request present, one bit per requester |
| req_write | input | NUM_REQ | 1 = write, 0 = read |
| req_class | input | NUM_REQ | 1 = latency-intolerant, 0 = latency-tolerant |
| req_addr | input | NUM_REQ*ADDR_W | Word address per requester, requester r at bits r*ADDR_W upward |
| req_wdata | input | NUM_REQ*64 | Write data per requester |
| req_gnt | output | NUM_REQ | Request accepted this cycle |
| rsp_valid | output | NUM_REQ | Read data valid, one cycle after a read grant |
| rsp_rdata | output | NUM_REQ*64 | Read data per requester |

## Verification
Requests to six distinct banks tell per-bank parallel grants apart from a single shared arbiter. Pairs of addresses that differ only in the low or only in the upper bits confirm which address bits pick the bank. Contention patterns at one bank separate the ordering rules from one another:
- an urgent request against a fresh tolerant one checks class priority;
- two urgent requesters that keep requesting check round-robin alternation;
- two urgent streams against one tolerant request check that promotion lands on exactly the ninth cycle.

A long seeded random mix of classes, reads and writes over a small prewritten region then checks read data against a model memory and checks the response timing.

// File: rtl/spad_pkg.sv
package spad_pkg;
  // Word width moved per port access
  localparam int DATA_W = 64;
  // Banks grouped into one slice
  localparam int BANKS_PER_SLICE = 4;

  typedef enum logic {
    CLS_TOLERANT = 1'b0,
    CLS_URGENT   = 1'b1
  } traffic_cls_e;
endpackage

// File: rtl/spad_starve.sv
// Per-requester count of consecutive denied cycles for latency-tolerant traffic.
module spad_starve #(
  parameter int NUM_REQ      = 6,
  parameter int STARVE_LIMIT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_valid,
  input  logic [NUM_REQ-1:0] req_urgent,
  input  logic [NUM_REQ-1:0] req_gnt,
  output logic [NUM_REQ-1:0] promo
);
  localparam int CW = $clog2(STARVE_LIMIT + 1);

  logic [CW-1:0] wait_q [NUM_REQ];
  logic [CW-1:0] wait_d [NUM_REQ];

  always_comb begin
    for (int r = 0; r < NUM_REQ; r++) begin
      promo[r] = (wait_q[r] == CW'(STARVE_LIMIT));
      if (req_valid[r] && !req_urgent[r] && !req_gnt[r]) begin
        wait_d[r] = promo[r] ? wait_q[r] : wait_q[r] + CW'(1);
      end else begin
        wait_d[r] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REQ; r++) wait_q[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REQ; r++) wait_q[r] <= wait_d[r];
    end
  end
endmodule

// File: rtl/spad_bank_arb.sv
// One bank's arbiter: promoted > urgent > tolerant, round-robin inside a tier.
module spad_bank_arb #(
  parameter int NUM_REQ = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_tgt,
  input  logic [NUM_REQ-1:0] req_urgent,
  input  logic [NUM_REQ-1:0] req_promo,
  output logic [NUM_REQ-1:0] gnt
);
  localparam int PW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [PW-1:0]      ptr_q, ptr_d;
  logic [NUM_REQ-1:0] promo_m, hi_m, lo_m, pick_m;
  logic               ptr_en;

  always_comb begin
    promo_m = req_tgt & req_promo & ~req_urgent;
    hi_m    = req_tgt & req_urgent;
    lo_m    = req_tgt & ~req_urgent;
    if (|promo_m)   pick_m = promo_m;
    else if (|hi_m) pick_m = hi_m;
    else            pick_m = lo_m;
  end

  always_comb begin : rr_scan
    logic found;
    int   idx;
    found = 1'b0;
    gnt   = '0;
    ptr_d = ptr_q;
    for (int k = 0; k < NUM_REQ; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= NUM_REQ) idx = idx - NUM_REQ;
      if (!found && pick_m[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        ptr_d    = (idx == NUM_REQ - 1) ? '0 : PW'(idx + 1);
      end
    end
  end

  assign ptr_en = |gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/spad_bank_ram.sv
// Single-port bank with a registered read port.
module spad_bank_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 64
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] row,
  input  logic [WIDTH-1:0]         wdata,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      else    rdata    <= mem[row];
    end
  end
endmodule

// File: rtl/spad_xbar.sv
module spad_xbar
  import spad_pkg::*;
#(
  parameter int  NUM_REQ      = 6,
  parameter int  NUM_SLICES   = 2,
  parameter int  BANK_DEPTH   = 256,
  parameter int  STARVE_LIMIT = 8,
  localparam int ADDR_W       = $clog2(BANKS_PER_SLICE * NUM_SLICES) + $clog2(BANK_DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_REQ-1:0]          req_valid,
  input  logic [NUM_REQ-1:0]          req_write,
  input  logic [NUM_REQ-1:0]          req_class,
  input  logic [NUM_REQ*ADDR_W-1:0]   req_addr,
  input  logic [NUM_REQ*DATA_W-1:0]   req_wdata,
  output logic [NUM_REQ-1:0]          req_gnt,
  output logic [NUM_REQ-1:0]          rsp_valid,
  output logic [NUM_REQ*DATA_W-1:0]   rsp_rdata
);
  localparam int NUM_BANKS = BANKS_PER_SLICE * NUM_SLICES;
  localparam int BB        = $clog2(NUM_BANKS);
  localparam int RW        = $clog2(BANK_DEPTH);

  logic [BB-1:0]      bank_of [NUM_REQ];
  logic [RW-1:0]      row_of  [NUM_REQ];
  logic [NUM_REQ-1:0] urgent;
  logic [NUM_REQ-1:0] promo;
  logic [NUM_REQ-1:0] gnt_mat [NUM_BANKS];
  logic [DATA_W-1:0]  bank_rd [NUM_BANKS];

  logic [NUM_REQ-1:0] rsp_v_q, rsp_v_d;
  logic [BB-1:0]      rsp_bank_q [NUM_REQ];

  // Word-interleaved address split
  always_comb begin
    for (int r = 0; r < NUM_REQ; r++) begin
      bank_of[r] = req_addr[r*ADDR_W +: BB];
      row_of[r]  = req_addr[r*ADDR_W + BB +: RW];
      urgent[r]  = (req_class[r] == CLS_URGENT);
    end
  end

  spad_starve #(
    .NUM_REQ      (NUM_REQ),
    .STARVE_LIMIT (STARVE_LIMIT)
  ) starve_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_urgent (urgent),
    .req_gnt    (req_gnt),
    .promo      (promo)
  );

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    for (genvar q = 0; q < BANKS_PER_SLICE; q++) begin : g_bank
      localparam int B = s * BANKS_PER_SLICE + q;

      logic [NUM_REQ-1:0] tgt;
      logic               sel_we;
      logic [RW-1:0]      sel_row;
      logic [DATA_W-1:0]  sel_wd;

      always_comb begin
        for (int r = 0; r < NUM_REQ; r++) begin
          tgt[r] = req_valid[r] && (bank_of[r] == BB'(B));
        end
      end

      spad_bank_arb #(
        .NUM_REQ (NUM_REQ)
      ) arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_tgt    (tgt),
        .req_urgent (urgent),
        .req_promo  (promo),
        .gnt        (gnt_mat[B])
      );

      // One-hot select of the winning request's fields
      always_comb begin
        sel_we  = 1'b0;
        sel_row = '0;
        sel_wd  = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
          if (gnt_mat[B][r]) begin
            sel_we  = sel_we  | req_write[r];
            sel_row = sel_row | row_of[r];
            sel_wd  = sel_wd  | req_wdata[r*DATA_W +: DATA_W];
          end
        end
      end

      spad_bank_ram #(
        .DEPTH (BANK_DEPTH),
        .WIDTH (DATA_W)
      ) ram_i (
        .clk   (clk),
        .en    (|gnt_mat[B]),
        .we    (sel_we),
        .row   (sel_row),
        .wdata (sel_wd),
        .rdata (bank_rd[B])
      );
    end
  end

  always_comb begin
    req_gnt = '0;
    for (int b = 0; b < NUM_BANKS; b++) req_gnt = req_gnt | gnt_mat[b];
    rsp_v_d = req_gnt & ~req_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= '0;
    end else begin
      rsp_v_q <= rsp_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REQ; r++) rsp_bank_q[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (req_gnt[r]) rsp_bank_q[r] <= bank_of[r];
      end
    end
  end

  always_comb begin
    rsp_valid = rsp_v_q;
    for (int r = 0; r < NUM_REQ; r++) begin
      rsp_rdata[r*DATA_W +: DATA_W] = rsp_v_q[r] ? bank_rd[rsp_bank_q[r]] : '0;
    end
  end
endmodule

// File: rtl/spad_xbar_chk.sv
module spad_xbar_chk #(
  parameter int NUM_REQ      = 6,
  parameter int NUM_SLICES   = 2,
  parameter int BANK_DEPTH   = 256,
  parameter int STARVE_LIMIT = 8
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic [NUM_REQ-1:0]                     req_valid,
  input logic [NUM_REQ-1:0]                     req_write,
  input logic [NUM_REQ-1:0]                     req_class,
  input logic [NUM_REQ*($clog2(4*NUM_SLICES)+$clog2(BANK_DEPTH))-1:0] req_addr,
  input logic [NUM_REQ-1:0]                     req_gnt,
  input logic [NUM_REQ-1:0]                     rsp_valid
);
  localparam int NUM_BANKS = 4 * NUM_SLICES;
  localparam int BB        = $clog2(NUM_BANKS);
  localparam int AW        = BB + $clog2(BANK_DEPTH);
  localparam int BOUND     = STARVE_LIMIT + NUM_REQ;
  localparam int WW        = $clog2(BOUND + 2) + 1;

  logic [NUM_REQ-1:0] tgtm [NUM_BANKS];
  logic [NUM_REQ-1:0] urgent_rival;
  logic [WW-1:0]      wc [NUM_REQ];

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        tgtm[b][r] = req_valid[r] && (req_addr[r*AW +: BB] == BB'(b));
      end
    end
    for (int r = 0; r < NUM_REQ; r++) begin
      urgent_rival[r] = |(tgtm[req_addr[r*AW +: BB]] & req_class);
    end
  end

  // Observer count of consecutive denied cycles for tolerant requests
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REQ; r++) wc[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (req_valid[r] && !req_class[r] && !req_gnt[r]) begin
          if (wc[r] != {WW{1'b1}}) wc[r] <= wc[r] + WW'(1);
        end else begin
          wc[r] <= '0;
        end
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    assert_one_per_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_gnt & tgtm[b]));
    assert_bank_served_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|tgtm[b]) |-> (|(req_gnt & tgtm[b])));
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_r
    assert_gnt_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_gnt[r] |-> req_valid[r]);
    assert_urgent_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_gnt[r] && !req_class[r] && (wc[r] < WW'(STARVE_LIMIT))) |-> !urgent_rival[r]);
    assert_starve_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wc[r] <= WW'(BOUND));
    assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_gnt[r] && !req_write[r]) |=> rsp_valid[r]);
    assert_rsp_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[r] |-> $past(req_gnt[r] && !req_write[r]));
    assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[r] && !req_gnt[r]) |=>
        (req_valid[r] && $stable(req_addr[r*AW +: AW]) && $stable(req_write[r])));
  end
endmodule

bind spad_xbar spad_xbar_chk #(
  .NUM_REQ      (NUM_REQ),
  .NUM_SLICES   (NUM_SLICES),
  .BANK_DEPTH   (BANK_DEPTH),
  .STARVE_LIMIT (STARVE_LIMIT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_class (req_class),
  .req_addr  (req_addr),
  .req_gnt   (req_gnt),
  .rsp_valid (rsp_valid)
);

// File: tb/spad_xbar_tb_top.sv
module spad_xbar_tb_top;
  localparam int NR = 6;
  localparam int NS = 2;
  localparam int NB = 8;
  localparam int DEPTH = 256;
  localparam int AW = 11;
  localparam int DW = 64;
  localparam int LIMIT = 8;

  logic                 clk;
  logic                 rst_n;
  logic [NR-1:0]        req_valid, req_write, req_class;
  logic [NR*AW-1:0]     req_addr;
  logic [NR*DW-1:0]     req_wdata;
  logic [NR-1:0]        req_gnt, rsp_valid;
  logic [NR*DW-1:0]     rsp_rdata;

  spad_xbar #(
    .NUM_REQ      (NR),
    .NUM_SLICES   (NS),
    .BANK_DEPTH   (DEPTH),
    .STARVE_LIMIT (LIMIT)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_class (req_class),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_gnt   (req_gnt),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Pending request state per requester
  logic          pv [NR];
  logic          pw [NR];
  logic          pc [NR];
  logic [AW-1:0] pa [NR];
  logic [DW-1:0] pd [NR];
  // Expected responses for the next cycle
  logic          ev [NR];
  logic [DW-1:0] ed [NR];
  int            wt [NR];
  logic [NR-1:0] g;
  logic [DW-1:0] mdl [64];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int bank_of(input logic [AW-1:0] a);
    return int'(a[2:0]);
  endfunction

  task automatic step();
    int ng, nq;
    @(negedge clk);
    for (int r = 0; r < NR; r++) begin
      chk(rsp_valid[r] == ev[r], "R8 rsp_valid", 64'(rsp_valid[r]), 64'(ev[r]));
      if (ev[r]) chk(rsp_rdata[r*DW +: DW] == ed[r], "R4 read data", rsp_rdata[r*DW +: DW], ed[r]);
      else       chk(rsp_rdata[r*DW +: DW] == '0, "R8 idle data", rsp_rdata[r*DW +: DW], 64'd0);
    end
    for (int r = 0; r < NR; r++) begin
      req_valid[r]           = pv[r];
      req_write[r]           = pw[r];
      req_class[r]           = pc[r];
      req_addr[r*AW +: AW]   = pa[r];
      req_wdata[r*DW +: DW]  = pd[r];
    end
    #1;
    g = req_gnt;
    for (int r = 0; r < NR; r++) begin
      if (g[r]) chk(pv[r], "R2 grant without request", 64'(g[r]), 64'(0));
    end
    for (int b = 0; b < NB; b++) begin
      ng = 0; nq = 0;
      for (int r = 0; r < NR; r++) begin
        if (pv[r] && bank_of(pa[r]) == b) begin
          nq++;
          if (g[r]) ng++;
        end
      end
      chk(ng <= 1, "R2 grants per bank", 64'(ng), 64'(1));
      if (nq > 0) chk(ng == 1, "R3 bank served", 64'(ng), 64'(1));
    end
    for (int r = 0; r < NR; r++) begin
      if (g[r] && !pc[r]) begin
        for (int o = 0; o < NR; o++) begin
          if (o != r && pv[o] && pc[o] && bank_of(pa[o]) == bank_of(pa[r]))
            chk(wt[r] >= LIMIT, "R5 urgent first", 64'(wt[r]), 64'(LIMIT));
        end
      end
    end
    for (int r = 0; r < NR; r++) begin
      ev[r] = 1'b0;
      if (g[r] && pw[r]) mdl[pa[r][5:0]] = pd[r];
    end
    for (int r = 0; r < NR; r++) begin
      if (g[r] && !pw[r]) begin
        ev[r] = 1'b1;
        ed[r] = mdl[pa[r][5:0]];
      end
      if (pv[r] && !pc[r] && !g[r]) wt[r]++;
      else wt[r] = 0;
      chk(wt[r] <= LIMIT + NR, "R7 wait bound", 64'(wt[r]), 64'(LIMIT + NR));
      if (g[r]) pv[r] = 1'b0;
    end
  endtask

  task automatic issue(input int r, input bit w, input bit c, input int a, input logic [63:0] d);
    pv[r] = 1'b1; pw[r] = w; pc[r] = c; pa[r] = AW'(a); pd[r] = d;
  endtask

  task automatic drain();
    bit busy;
    busy = 1'b1;
    while (busy) begin
      busy = 1'b0;
      for (int r = 0; r < NR; r++) if (pv[r]) busy = 1'b1;
      if (busy) step();
    end
    step();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    int last;
    void'($urandom(32'd20240611));
    for (int r = 0; r < NR; r++) begin
      pv[r] = 0; pw[r] = 0; pc[r] = 0; pa[r] = '0; pd[r] = '0;
      ev[r] = 0; ed[r] = '0; wt[r] = 0;
    end
    rst_n = 1'b0;
    req_valid = '0; req_write = '0; req_class = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rsp_valid == '0, "R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(req_gnt == '0, "R9 no request no grant", 64'(req_gnt), 64'd0);
    chk(rsp_rdata == '0, "R9 reset data", rsp_rdata[63:0], 64'd0);

    // Prewrite words 0..63 (rows 0..7 of every bank), spread across requesters
    for (int a = 0; a < 64; a++) begin
      while (pv[a % NR]) step();
      issue(a % NR, 1'b1, a[0], a, {$urandom, $urandom});
    end
    drain();

    // R3: six reads to six distinct banks, granted in one cycle
    for (int r = 0; r < NR; r++) issue(r, 1'b0, r[0], 8 + r, '0);
    step();
    chk(g == 6'b111111, "R3 parallel banks", 64'(g), 64'h3f);
    drain();

    // R1: same low bits conflict, different low bits proceed together
    issue(0, 1'b0, 1'b1, 3, '0);
    issue(1, 1'b0, 1'b1, 11, '0);
    step();
    chk($countones(g[1:0]) == 1, "R1 same bank conflict", 64'(g), 64'd1);
    drain();
    issue(0, 1'b0, 1'b1, 3, '0);
    issue(1, 1'b0, 1'b1, 4, '0);
    step();
    chk(g[1:0] == 2'b11, "R1 distinct banks", 64'(g), 64'd3);
    drain();

    // R4: write through one requester, read through another
    issue(2, 1'b1, 1'b0, 21, 64'hdead_beef_0123_4567);
    step();
    issue(5, 1'b0, 1'b1, 21, '0);
    step();
    chk(g[5], "R4 read after write granted", 64'(g), 64'h20);
    drain();

    // R5: urgent beats a fresh tolerant request
    issue(0, 1'b0, 1'b0, 2, '0);
    issue(1, 1'b0, 1'b1, 10, '0);
    step();
    chk(g[1:0] == 2'b10, "R5 urgent first", 64'(g), 64'd2);
    step();
    chk(g[0], "R5 tolerant next", 64'(g), 64'd1);
    drain();

    // R6: two urgent requesters keep asking one bank and alternate
    last = -1;
    for (int i = 0; i < 8; i++) begin
      if (!pv[3]) issue(3, 1'b0, 1'b1, 5, '0);
      if (!pv[4]) issue(4, 1'b0, 1'b1, 13, '0);
      step();
      if (last >= 0) chk(!g[last], "R6 round-robin alternation", 64'(g), 64'd0);
      last = g[3] ? 3 : 4;
    end
    drain();

    // R7: tolerant request against two steady urgent streams
    issue(2, 1'b0, 1'b0, 16, '0);
    cnt = 0;
    for (int i = 0; i < 20 && pv[2]; i++) begin
      if (!pv[0]) issue(0, 1'b0, 1'b1, 0, '0);
      if (!pv[1]) issue(1, 1'b0, 1'b1, 8, '0);
      step();
      if (!g[2]) cnt++;
    end
    chk(cnt == LIMIT, "R7 promotion after denials", 64'(cnt), 64'(LIMIT));
    drain();

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      for (int r = 0; r < NR; r++) begin
        if (!pv[r] && ($urandom % 2 == 0))
          issue(r, ($urandom % 3) == 0, $urandom % 2, int'($urandom % 64), {$urandom, $urandom});
      end
      step();
    end
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule